// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block is the controller-side state machine that takes a DDR2 SDRAM from power-up to the point where normal traffic may start. It owns the clock-enable, on-die-termination and command/address pins while the sequence runs. It converts the long analogue settling waits into clock counts at elaboration time. It then issues a fixed series of precharge-all, register-write and auto-refresh commands, each separated by the minimum spacing that the device needs.

The mode-register and extended-register-1 words come from parameters: burst length, burst order, CAS latency, write recovery, additive latency, drive strength, termination value, strobe options and power-down exit speed. The write-recovery code is derived from a recovery time in picoseconds and the clock period. The block marks each command cycle with a strobe. When the final calibration-exit write has had its settling time, it raises a sticky ready flag.

Top module: `dram_init_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cke`, `odt`, `cmd_valid` and `init_done` are low. The bus shows deselect: `cs_n`, `ras_n`, `cas_n` and `we_n` are high, and `ba` and `addr` are zero.
- R2: After reset is released, `cke` stays low for exactly ceil(POWER_WAIT_PS/CLK_PS) cycles, then rises. The first precharge-all follows exactly ceil(CKE_WAIT_PS/CLK_PS) cycles after the rise. No command is issued while `cke` is low.
- R3: The commands appear in this order: precharge-all, then writes to extended register 2, extended register 3 and extended register 1 (DLL on), then a mode write with DLL reset. Next come precharge-all, the refresh burst and a mode write without DLL reset. The sequence ends with two extended-register-1 writes: calibration default, then calibration exit.
- R4: Command encodings as {cs_n,ras_n,cas_n,we_n} are: deselect = 1111, precharge-all = 0010 with addr = 0x0400 (A10) and ba = 0, auto-refresh = 0001 with addr = 0 and ba = 0, register write = 0000. For a register write, ba selects the target: 000 mode, 001 extended 1, 010 extended 2, 011 extended 3. The words for extended 2 and 3 are zero.
- R5: The mode word places the burst length at addr[2:0] (010 = 4, 011 = 8) and the burst order at addr[3] (1 = interleaved). CAS latency goes at addr[6:4] as its binary value (3..7), and addr[7] is 0. DLL reset is addr[8], set only in the first mode write. Write recovery is addr[11:9] = cycles-1, where cycles = ceil(TWR_PS/CLK_PS) limited to 2..8. The slow power-down exit is addr[12], and addr[13] is 0.
- R6: The extended-register-1 word has addr[0] = 0 (DLL enabled) and addr[1] = reduced drive. The termination selection is {addr[6],addr[2]}, additive latency is addr[5:3], calibration control is addr[9:7], strobe-complement disable is addr[10] and read-strobe enable is addr[11].
- R7: After a register write, the next command follows exactly T_MRD cycles later, except for the calibration-default write (see R9). After a precharge-all the gap is exactly T_RP cycles, and after an auto-refresh it is exactly T_RFC cycles.
- R8: The refresh burst holds exactly REFRESH_COUNT auto-refresh commands. A value below 2 is raised to 2.
- R9: The calibration-default write (addr[9:7] = 111) is issued no earlier than DLL_CYCLES cycles after the DLL-reset mode write, and no earlier than T_MRD after the preceding mode write. Its gap is the larger of the two. The calibration-exit write (addr[9:7] = 000) follows T_MRD later. All other fields equal the first extended-register-1 word in both writes.
- R10: `init_done` rises exactly T_MRD cycles after the calibration-exit write and stays high until reset. From then on, only deselect is driven and `cmd_valid` stays low.
- R11: `cmd_valid` is high exactly in the cycles that carry a non-deselect command, and `odt` is low at all times.
- R12: Asserting `rst` at any point, including mid-sequence or after `init_done`, returns the block to the R1 state and restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination enable, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank / register select |
| addr | output | 14 | Address / register word |
| cmd_valid | output | 1 | High in each cycle that carries a command |
| init_done | output | 1 | Sticky: device ready for normal operation |

## Verification
A wrong step register or a skipped transition shows at the ports at the very next command. That command carries the wrong register select, the wrong word, or a gap that differs from the exact spacing, so every command is compared for value and for cycle distance from the previous one. A miscounting refresh or DLL-settling counter shows as an extra or missing refresh, or a calibration-default gap other than the one computed. A stuck ready flag or a late command after completion shows in the idle window that follows `init_done`. A reset taken mid-sequence must produce the full power-wait count again, so stale timer or step state is visible within one sequence.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_PREALL,
        CMD_REFRESH,
        CMD_REGWR
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_POWER,
        ST_CKE_UP,
        ST_PRE_FIRST,
        ST_EXT2,
        ST_EXT3,
        ST_EXT1_DLL,
        ST_MODE_RST,
        ST_PRE_SECOND,
        ST_REFRESH,
        ST_MODE_RUN,
        ST_CAL_DEFAULT,
        ST_CAL_EXIT,
        ST_READY
    } step_e;

    typedef struct packed {
        logic        cs_n;
        logic        ras_n;
        logic        cas_n;
        logic        we_n;
        logic [2:0]  ba;
        logic [13:0] addr;
    } dram_bus_t;

    localparam dram_bus_t IDLE_BUS = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                       we_n: 1'b1, ba: 3'b000, addr: 14'h0000};

    localparam logic [2:0]  SEL_MODE      = 3'b000;
    localparam logic [2:0]  SEL_EXT1      = 3'b001;
    localparam logic [2:0]  SEL_EXT2      = 3'b010;
    localparam logic [2:0]  SEL_EXT3      = 3'b011;
    localparam int          MODE_DLL_RST_BIT = 8;
    localparam logic [13:0] ALL_BANKS_ADDR = 14'h0400;
    localparam logic [2:0]  CAL_DEFAULT_CODE = 3'b111;
    localparam logic [2:0]  CAL_EXIT_CODE    = 3'b000;

    function automatic int ceil_div(int num, int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least(int v, int lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic int clamp(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int recovery_cycles(int twr_ps, int clk_ps);
        return clamp(ceil_div(twr_ps, clk_ps), 2, 8);
    endfunction

    function automatic logic [13:0] mode_word(int burst_len, int interleave,
                                              int cas_lat, int wr_cyc,
                                              int slow_exit);
        logic [13:0] w;
        w        = '0;
        w[2:0]   = (burst_len == 8) ? 3'b011 : 3'b010;
        w[3]     = (interleave != 0);
        w[6:4]   = 3'(cas_lat);
        w[11:9]  = 3'(wr_cyc - 1);
        w[12]    = (slow_exit != 0);
        return w;
    endfunction

    function automatic logic [13:0] ext1_word(int reduced, int odt_sel,
                                              int add_lat, int dqsn_off,
                                              int rdqs_on);
        logic [13:0] w;
        logic [1:0]  sel;
        sel      = 2'(odt_sel);
        w        = '0;
        w[1]     = (reduced != 0);
        w[2]     = sel[0];
        w[5:3]   = 3'(add_lat);
        w[6]     = sel[1];
        w[10]    = (dqsn_off != 0);
        w[11]    = (rdqs_on != 0);
        return w;
    endfunction

    function automatic logic [13:0] with_cal(logic [13:0] w, logic [2:0] code);
        logic [13:0] r;
        r      = w;
        r[9:7] = code;
        return r;
    endfunction

    function automatic dram_bus_t make_bus(cmd_kind_e kind, logic [2:0] sel,
                                           logic [13:0] word);
        dram_bus_t b;
        b = IDLE_BUS;
        case (kind)
            CMD_PREALL: begin
                b.cs_n = 1'b0; b.ras_n = 1'b0; b.cas_n = 1'b1; b.we_n = 1'b0;
                b.addr = ALL_BANKS_ADDR;
            end
            CMD_REFRESH: begin
                b.cs_n = 1'b0; b.ras_n = 1'b0; b.cas_n = 1'b0; b.we_n = 1'b1;
            end
            CMD_REGWR: begin
                b.cs_n = 1'b0; b.ras_n = 1'b0; b.cas_n = 1'b0; b.we_n = 1'b0;
                b.ba   = sel;
                b.addr = word;
            end
            default: b = IDLE_BUS;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
    parameter int WIDTH     = 8,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= WIDTH'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R7: once expired and not reloaded, the timer stays expired
    assert_timer_rest_R7: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired)
        else $error("timer left zero without a load");

endmodule

// File: rtl/dram_init_dll_wait.sv
module dram_init_dll_wait #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready
);
    localparam int N = (CYCLES < 1) ? 1 : CYCLES;
    localparam int W = $clog2(N + 1);
    localparam logic [W-1:0] LAST = W'(N - 1);

    logic [W-1:0] cnt_q;
    logic         run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // counter value equals cycles elapsed since the DLL-reset command cycle
    assign ready = run_q && (cnt_q == LAST);

    assert_ready_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready)
        else $error("settling window dropped");

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q <= LAST))
        else $error("settling counter overran");

endmodule

// File: rtl/dram_init_cmd_gen.sv
module dram_init_cmd_gen
    import dram_init_pkg::*;
#(
    parameter logic [13:0] MODE_BASE = 14'h0000,
    parameter logic [13:0] EXT1_BASE = 14'h0000
) (
    input  step_e     step,
    output dram_bus_t bus,
    output logic      valid
);
    localparam logic [13:0] MODE_RST_WORD = MODE_BASE | (14'd1 << MODE_DLL_RST_BIT);

    always_comb begin
        bus   = IDLE_BUS;
        valid = 1'b1;
        case (step)
            ST_PRE_FIRST,
            ST_PRE_SECOND:  bus = make_bus(CMD_PREALL, SEL_MODE, '0);
            ST_EXT2:        bus = make_bus(CMD_REGWR, SEL_EXT2, '0);
            ST_EXT3:        bus = make_bus(CMD_REGWR, SEL_EXT3, '0);
            ST_EXT1_DLL:    bus = make_bus(CMD_REGWR, SEL_EXT1, with_cal(EXT1_BASE, CAL_EXIT_CODE));
            ST_MODE_RST:    bus = make_bus(CMD_REGWR, SEL_MODE, MODE_RST_WORD);
            ST_REFRESH:     bus = make_bus(CMD_REFRESH, SEL_MODE, '0);
            ST_MODE_RUN:    bus = make_bus(CMD_REGWR, SEL_MODE, MODE_BASE);
            ST_CAL_DEFAULT: bus = make_bus(CMD_REGWR, SEL_EXT1, with_cal(EXT1_BASE, CAL_DEFAULT_CODE));
            ST_CAL_EXIT:    bus = make_bus(CMD_REGWR, SEL_EXT1, with_cal(EXT1_BASE, CAL_EXIT_CODE));
            default: begin
                bus   = IDLE_BUS;
                valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dram_init_sequencer.sv
module dram_init_sequencer
    import dram_init_pkg::*;
#(
    parameter int CLK_PS           = 20000,
    parameter int POWER_WAIT_PS    = 200000000,
    parameter int CKE_WAIT_PS      = 400000,
    parameter int T_MRD            = 2,
    parameter int T_RP             = 3,
    parameter int T_RFC            = 8,
    parameter int REFRESH_COUNT    = 2,
    parameter int DLL_CYCLES       = 200,
    parameter int BURST_LEN        = 4,
    parameter int BURST_INTERLEAVE = 0,
    parameter int CAS_LAT          = 3,
    parameter int TWR_PS           = 15000,
    parameter int SLOW_PD_EXIT     = 0,
    parameter int ADD_LAT          = 0,
    parameter int REDUCED_DRIVE    = 0,
    parameter int ODT_SEL          = 0,
    parameter int DQSN_DISABLE     = 0,
    parameter int RDQS_ENABLE      = 0
) (
    input  logic        clk,
    input  logic        rst,
    output logic        cke,
    output logic        odt,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [2:0]  ba,
    output logic [13:0] addr,
    output logic        cmd_valid,
    output logic        init_done
);
    localparam int PWR_CYC = at_least(ceil_div(POWER_WAIT_PS, CLK_PS), 1);
    localparam int CKE_CYC = at_least(ceil_div(CKE_WAIT_PS, CLK_PS), 1);
    localparam int MRD_CYC = at_least(T_MRD, 1);
    localparam int RP_CYC  = at_least(T_RP, 1);
    localparam int RFC_CYC = at_least(T_RFC, 1);
    localparam int REF_N   = at_least(REFRESH_COUNT, 2);
    localparam int TMAX    = max2(max2(PWR_CYC, CKE_CYC), max2(max2(MRD_CYC, RP_CYC), RFC_CYC));
    localparam int TW      = $clog2(TMAX + 1);
    localparam int RW      = $clog2(REF_N + 1);
    localparam int WR_CYC  = recovery_cycles(TWR_PS, CLK_PS);
    localparam int CL_EFF  = clamp(CAS_LAT, 3, 7);
    localparam logic [13:0] MODE_BASE = mode_word(BURST_LEN, BURST_INTERLEAVE, CL_EFF,
                                                  WR_CYC, SLOW_PD_EXIT);
    localparam logic [13:0] EXT1_BASE = ext1_word(REDUCED_DRIVE, ODT_SEL, ADD_LAT,
                                                  DQSN_DISABLE, RDQS_ENABLE);

    step_e          step_q;
    step_e          nxt_step;
    logic           adv;
    logic           t_expired;
    logic           dll_ready;
    logic [TW-1:0]  gap_m1;
    logic [RW-1:0]  refs_q;
    dram_bus_t      nxt_bus;
    dram_bus_t      bus_q;
    logic           nxt_valid;
    logic           valid_q;
    logic           cke_q;
    logic           done_q;

    // successor of the current step
    always_comb begin
        case (step_q)
            ST_POWER:       nxt_step = ST_CKE_UP;
            ST_CKE_UP:      nxt_step = ST_PRE_FIRST;
            ST_PRE_FIRST:   nxt_step = ST_EXT2;
            ST_EXT2:        nxt_step = ST_EXT3;
            ST_EXT3:        nxt_step = ST_EXT1_DLL;
            ST_EXT1_DLL:    nxt_step = ST_MODE_RST;
            ST_MODE_RST:    nxt_step = ST_PRE_SECOND;
            ST_PRE_SECOND:  nxt_step = ST_REFRESH;
            ST_REFRESH:     nxt_step = (refs_q == RW'(REF_N)) ? ST_MODE_RUN : ST_REFRESH;
            ST_MODE_RUN:    nxt_step = ST_CAL_DEFAULT;
            ST_CAL_DEFAULT: nxt_step = ST_CAL_EXIT;
            ST_CAL_EXIT:    nxt_step = ST_READY;
            default:        nxt_step = ST_READY;
        endcase
    end

    // minimum spacing that the step about to start imposes on what follows
    always_comb begin
        case (nxt_step)
            ST_POWER:                    gap_m1 = TW'(PWR_CYC - 1);
            ST_CKE_UP:                   gap_m1 = TW'(CKE_CYC - 1);
            ST_PRE_FIRST, ST_PRE_SECOND: gap_m1 = TW'(RP_CYC - 1);
            ST_REFRESH:                  gap_m1 = TW'(RFC_CYC - 1);
            ST_READY:                    gap_m1 = '0;
            default:                     gap_m1 = TW'(MRD_CYC - 1);
        endcase
    end

    assign adv = t_expired && (step_q != ST_READY) &&
                 !((step_q == ST_MODE_RUN) && !dll_ready);

    dram_init_timer #(
        .WIDTH     (TW),
        .RESET_VAL (PWR_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (adv),
        .load_val (gap_m1),
        .expired  (t_expired)
    );

    dram_init_dll_wait #(
        .CYCLES (DLL_CYCLES)
    ) u_dll_wait (
        .clk   (clk),
        .rst   (rst),
        .start (adv && (nxt_step == ST_MODE_RST)),
        .ready (dll_ready)
    );

    dram_init_cmd_gen #(
        .MODE_BASE (MODE_BASE),
        .EXT1_BASE (EXT1_BASE)
    ) u_cmd_gen (
        .step  (nxt_step),
        .bus   (nxt_bus),
        .valid (nxt_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_POWER;
            bus_q   <= IDLE_BUS;
            valid_q <= 1'b0;
            cke_q   <= 1'b0;
            done_q  <= 1'b0;
            refs_q  <= '0;
        end else if (adv) begin
            step_q  <= nxt_step;
            bus_q   <= nxt_bus;
            valid_q <= nxt_valid;
            if (nxt_step == ST_CKE_UP) cke_q  <= 1'b1;
            if (nxt_step == ST_READY)  done_q <= 1'b1;
            if (nxt_step == ST_REFRESH) refs_q <= refs_q + 1'b1;
        end else begin
            bus_q   <= IDLE_BUS;
            valid_q <= 1'b0;
        end
    end

    assign cke       = cke_q;
    assign odt       = 1'b0;
    assign cs_n      = bus_q.cs_n;
    assign ras_n     = bus_q.ras_n;
    assign cas_n     = bus_q.cas_n;
    assign we_n      = bus_q.we_n;
    assign ba        = bus_q.ba;
    assign addr      = bus_q.addr;
    assign cmd_valid = valid_q;
    assign init_done = done_q;

    // ---------------- checker support: spacing between commands -------------
    logic [15:0] since_q;
    logic [15:0] need_q;
    logic        seen_q;
    logic [15:0] need_now;

    always_comb begin
        case ({bus_q.ras_n, bus_q.cas_n, bus_q.we_n})
            3'b010:  need_now = 16'(RP_CYC);
            3'b001:  need_now = 16'(RFC_CYC);
            default: need_now = 16'(MRD_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            need_q  <= '0;
            seen_q  <= 1'b0;
        end else if (valid_q) begin
            since_q <= 16'd1;
            need_q  <= need_now;
            seen_q  <= 1'b1;
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    assert_min_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_q && seen_q) |-> (since_q >= need_q))
        else $error("command spacing too short");

    assert_cmd_needs_cke_R2: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> cke_q)
        else $error("command while clock enable low");

    assert_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        valid_q == !bus_q.cs_n)
        else $error("strobe does not match chip select");

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q)
        else $error("ready flag dropped");

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!valid_q && bus_q.cs_n))
        else $error("command after ready");

    assert_cal_after_dll_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_q && bus_q.ba == SEL_EXT1 && bus_q.addr[9:7] == CAL_DEFAULT_CODE)
            |-> $past(dll_ready))
        else $error("calibration before DLL settling");

endmodule

// File: tb/tb_dram_init_sequencer.sv
`timescale 1ns/1ps
module tb_dram_init_sequencer;

    localparam int PWR_EXP  = 10000;  // 200 us / 20 ns
    localparam int NCMD     = 12;
    localparam int REF_EXP  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke, odt, cs_n, ras_n, cas_n, we_n, cmd_valid, init_done;
    logic [2:0]  ba;
    logic [13:0] addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit odt_seen = 1'b0;
    int idle_bad = 0;

    always #10 clk = ~clk;

    dram_init_sequencer #(
        .CLK_PS(20000), .TWR_PS(45000), .BURST_LEN(8), .BURST_INTERLEAVE(1),
        .CAS_LAT(5), .ADD_LAT(2), .SLOW_PD_EXIT(1), .REDUCED_DRIVE(1),
        .ODT_SEL(1), .REFRESH_COUNT(REF_EXP), .T_MRD(2), .T_RP(3), .T_RFC(8),
        .DLL_CYCLES(200)
    ) dut (
        .clk(clk), .rst(rst), .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_valid(cmd_valid), .init_done(init_done)
    );

    // {cs,ras,cas,we}, ba, addr, cycles since previous command (or cke rise)
    localparam logic [36:0] EXP_TAB [NCMD] = '{
        {4'b0010, 3'd0, 14'h0400, 16'd20},   // precharge-all, 400 ns after cke
        {4'b0000, 3'd2, 14'h0000, 16'd3},    // ext2 after tRP
        {4'b0000, 3'd3, 14'h0000, 16'd2},    // ext3
        {4'b0000, 3'd1, 14'h0016, 16'd2},    // ext1, DLL on
        {4'b0000, 3'd0, 14'h155B, 16'd2},    // mode, DLL reset
        {4'b0010, 3'd0, 14'h0400, 16'd2},    // precharge-all
        {4'b0001, 3'd0, 14'h0000, 16'd3},    // refresh 1
        {4'b0001, 3'd0, 14'h0000, 16'd8},    // refresh 2
        {4'b0001, 3'd0, 14'h0000, 16'd8},    // refresh 3
        {4'b0000, 3'd0, 14'h145B, 16'd8},    // mode, run
        {4'b0000, 3'd1, 14'h0396, 16'd171},  // cal default: 200 - (2+3+8+8+8)
        {4'b0000, 3'd1, 14'h0016, 16'd2}     // cal exit
    };

    always @(negedge clk) begin
        if (odt) odt_seen = 1'b1;
        if (!rst && (cmd_valid == cs_n)) idle_bad++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string req);
        chk(cke == 1'b0, req, "cke in reset", cke, 0);
        chk(odt == 1'b0, req, "odt in reset", odt, 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b1111 && ba == 0 && addr == 0, req,
            "bus deselect in reset", {cs_n, ras_n, cas_n, we_n, ba, addr}, 21'h1E0000);
        chk(cmd_valid == 1'b0, req, "strobe in reset", cmd_valid, 0);
        chk(init_done == 1'b0, req, "ready in reset", init_done, 0);
    endtask

    task automatic run_seq(input int upto);
        int lowc;
        int gap;
        int refs;
        lowc = 0;
        refs = 0;
        @(negedge clk);
        rst = 1'b0;
        while (!cke && lowc < 20000) begin
            lowc++;
            @(negedge clk);
        end
        chk(lowc == PWR_EXP, "R2", "cke low cycles", lowc, PWR_EXP);
        for (int i = 0; i < upto; i++) begin
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!cmd_valid && gap < 1000);
            // R3 R4 R5 R6: order, encoding and register words
            chk({cs_n, ras_n, cas_n, we_n} == EXP_TAB[i][36:33], "R4",
                $sformatf("command code %0d", i), {cs_n, ras_n, cas_n, we_n}, EXP_TAB[i][36:33]);
            chk(ba == EXP_TAB[i][32:30] && addr == EXP_TAB[i][29:16],
                (i == 4 || i == 9) ? "R5" : ((i >= 10) ? "R9" : "R3"),
                $sformatf("ba/addr %0d", i), {ba, addr}, EXP_TAB[i][32:16]);
            // R7 exact spacing
            chk(gap == int'(EXP_TAB[i][15:0]), (i == 10) ? "R9" : "R7",
                $sformatf("gap before %0d", i), gap, EXP_TAB[i][15:0]);
            if ({ras_n, cas_n, we_n} == 3'b001) refs++;
        end
        if (upto == NCMD) begin
            chk(refs == REF_EXP, "R8", "refresh count", refs, REF_EXP);
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!init_done && gap < 1000);
            chk(gap == 2, "R10", "ready delay after cal exit", gap, 2);
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (!init_done || cmd_valid || !cs_n) gap = -1;
            end
            chk(gap != -1, "R10", "quiet and sticky after ready", gap, 2);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_reset_state("R1");
        // R6 word layout is cross-checked by entries 3, 10, 11 of the table
        run_seq(NCMD);
        chk(idle_bad == 0, "R11", "strobe vs chip select mismatches", idle_bad, 0);
        // R12: reset after ready
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk_reset_state("R12");
        // R12: reset mid-sequence, after the DLL-reset write
        run_seq(5);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk_reset_state("R12");
        run_seq(NCMD);
        chk(!odt_seen, "R11", "odt ever high", odt_seen, 0);
        chk(idle_bad == 0, "R11", "strobe vs chip select mismatches", idle_bad, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule